// File: doc/BRIEF.md
# Flash Byte Program-and-Verify Sequencer

This block sits on the host side of a parallel flash device. It writes one byte into the flash using a command-driven loop. A one-cycle start pulse brings in a 16-bit target address and an 8-bit value. The sequencer then drives chip enable, output enable, write enable, the address bus and a data bus that can be released.

Each attempt has four steps:
- a setup write carrying the program command (0x40);
- a second write carrying the target address and data;
- a fixed program wait;
- a verify write carrying the verify command (0xC0), followed by a read with output enable low.

The byte read back is compared with the intended value. A match ends the run with a `done` pulse. A mismatch starts another attempt. After the allowed number of attempts has failed, the run ends with a `fail` pulse.

Pin timing is set by parameters counted in clock cycles:
- address and data setup before write enable falls;
- write enable low width;
- hold after write enable rises;
- the program wait;
- the bus turnaround before a read;
- the output-enable read width.

All pin outputs come straight from flops. The data bus uses a separate output, output-enable and input, so a pad ring can build the tri-state.

Top module: `flash_byte_prog`

## Requirements
- R1: While reset is high and after it, until a start is accepted, chip enable, output enable and write enable are high (inactive), the data bus is released (`fl_dq_oe`=0), and `busy`, `done` and `fail` are low.
- R2: Every attempt begins with a write cycle carrying 0x40. The next write cycle carries the target address and data latched at start.
- R3: In each write cycle, address and data are driven for P_SETUP cycles before write enable falls. Write enable stays low for exactly P_WE_LOW cycles with the address unchanged. The data is still driven, unchanged, on the cycle write enable rises.
- R4: Between the rising write-enable edge of the program write and the rising edge of the following verify-command write, at least P_PROG + P_WE_LOW cycles pass.
- R5: The verify consists of a write cycle carrying 0xC0 followed by a read with output enable low. The data bus is released (`fl_dq_oe`=0) before, and for the whole time, output enable is low.
- R6: When the byte read back equals the target data, `done` pulses high for exactly one cycle, `busy` is low in that cycle, and `fail` stays low.
- R7: On a mismatch a new attempt starts (back to R2). At most P_MAX_TRIES program writes occur per start. If the last of them also reads back wrong, `fail` pulses for one cycle and `done` stays low.
- R8: A start pulse while `busy` is high has no effect: the address and data programmed, and the number of results reported, are those of the accepted start.
- R9: Write enable and output enable are never low together, and write enable is low only while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to program a byte |
| tgt_addr | input | 16 | Target address, sampled with start |
| tgt_data | input | 8 | Byte to program, sampled with start |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: byte verified |
| fail | output | 1 | One-cycle pulse: attempts exhausted |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | 16 | Flash address bus |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for the data bus |
| fl_dq_i | input | 8 | Data returned by the flash |

## Verification
The assertions take for granted that reset is applied before the first start. They also assume every timing parameter is at least one cycle and that the read width is at least two. The pin checks hold only under those settings.

They further assume the flash returns a settled byte by the last cycle of the read. The bench flash model drives its reply combinationally from its own state, so this always holds. The model changes its answer only at verify-command writes, and start pulses are driven away from clock edges.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSETUP,
    S_WLOW,
    S_WHIGH,
    S_PWAIT,
    S_RTURN,
    S_RLOW,
    S_CHECK
  } seq_state_t;

  typedef enum logic [1:0] {
    K_PROG_CMD,
    K_PROG_DATA,
    K_VERIFY_CMD
  } wr_kind_t;

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/flash_seq_tries.sv
module flash_seq_tries #(
  parameter int MAX_TRIES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic first,
  input  logic again,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

  logic [CW-1:0] tries;

  always_ff @(posedge clk) begin
    if (rst)        tries <= '0;
    else if (first) tries <= CW'(1);
    else if (again) tries <= tries + 1'b1;
  end

  assign exhausted = (tries >= LIMIT);
endmodule

// File: rtl/flash_seq_readback.sv
module flash_seq_readback #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] expect_val,
  output logic              match
);
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (capture) rd_q <= bus_in;
  end

  assign match = (rd_q == expect_val);
endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int P_SETUP     = 1,
  parameter int P_WE_LOW    = 2,
  parameter int P_WE_HIGH   = 1,
  parameter int P_PROG      = 500,
  parameter int P_TURN      = 1,
  parameter int P_READ      = 2,
  parameter int P_MAX_TRIES = 25,
  parameter logic [DATA_W-1:0] CMD_PROG   = 8'h40,
  parameter logic [DATA_W-1:0] CMD_VERIFY = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_i
);
  localparam int M1   = (P_SETUP > P_WE_LOW) ? P_SETUP : P_WE_LOW;
  localparam int M2   = (M1 > P_WE_HIGH) ? M1 : P_WE_HIGH;
  localparam int M3   = (M2 > P_PROG) ? M2 : P_PROG;
  localparam int M4   = (M3 > P_TURN) ? M3 : P_TURN;
  localparam int TMAX = (M4 > P_READ) ? M4 : P_READ;
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [TW-1:0] L_SETUP = TW'(P_SETUP - 1);
  localparam logic [TW-1:0] L_WLOW  = TW'(P_WE_LOW - 1);
  localparam logic [TW-1:0] L_WHIGH = TW'(P_WE_HIGH - 1);
  localparam logic [TW-1:0] L_PROG  = TW'(P_PROG - 1);
  localparam logic [TW-1:0] L_TURN  = TW'(P_TURN - 1);
  localparam logic [TW-1:0] L_READ  = TW'(P_READ - 1);

  seq_state_t        state_q, state_d;
  wr_kind_t          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_zero;
  logic          try_first, try_again, try_out;
  logic          rb_cap, rb_match;
  logic          done_d, fail_d;

  flash_seq_timer #(.W(TW)) timer_i (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  flash_seq_tries #(.MAX_TRIES(P_MAX_TRIES)) tries_i (
    .clk(clk), .rst(rst), .first(try_first), .again(try_again),
    .exhausted(try_out)
  );

  flash_seq_readback #(.DATA_W(DATA_W)) rb_i (
    .clk(clk), .rst(rst), .capture(rb_cap), .bus_in(fl_dq_i),
    .expect_val(data_q), .match(rb_match)
  );

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    t_load    = 1'b0;
    t_val     = '0;
    try_first = 1'b0;
    try_again = 1'b0;
    rb_cap    = 1'b0;
    done_d    = 1'b0;
    fail_d    = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d   = S_WSETUP;
        kind_d    = K_PROG_CMD;
        t_load    = 1'b1;
        t_val     = L_SETUP;
        try_first = 1'b1;
      end
      S_WSETUP: if (t_zero) begin
        state_d = S_WLOW;
        t_load  = 1'b1;
        t_val   = L_WLOW;
      end
      S_WLOW: if (t_zero) begin
        state_d = S_WHIGH;
        t_load  = 1'b1;
        t_val   = L_WHIGH;
      end
      S_WHIGH: if (t_zero) begin
        t_load = 1'b1;
        unique case (kind_q)
          K_PROG_CMD: begin
            state_d = S_WSETUP;
            kind_d  = K_PROG_DATA;
            t_val   = L_SETUP;
          end
          K_PROG_DATA: begin
            state_d = S_PWAIT;
            t_val   = L_PROG;
          end
          default: begin
            state_d = S_RTURN;
            t_val   = L_TURN;
          end
        endcase
      end
      S_PWAIT: if (t_zero) begin
        state_d = S_WSETUP;
        kind_d  = K_VERIFY_CMD;
        t_load  = 1'b1;
        t_val   = L_SETUP;
      end
      S_RTURN: if (t_zero) begin
        state_d = S_RLOW;
        t_load  = 1'b1;
        t_val   = L_READ;
      end
      S_RLOW: if (t_zero) begin
        state_d = S_CHECK;
        rb_cap  = 1'b1;
      end
      S_CHECK: begin
        if (rb_match) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else if (try_out) begin
          state_d = S_IDLE;
          fail_d  = 1'b1;
        end else begin
          state_d   = S_WSETUP;
          kind_d    = K_PROG_CMD;
          t_load    = 1'b1;
          t_val     = L_SETUP;
          try_again = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  logic              wr_phase, rd_phase;
  logic [DATA_W-1:0] dq_next;

  assign wr_phase = (state_q == S_WSETUP) || (state_q == S_WLOW) ||
                    (state_q == S_WHIGH);
  assign rd_phase = (state_q == S_RTURN) || (state_q == S_RLOW);

  always_comb begin
    unique case (kind_q)
      K_PROG_CMD:  dq_next = CMD_PROG;
      K_PROG_DATA: dq_next = data_q;
      default:     dq_next = CMD_VERIFY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      kind_q   <= K_PROG_CMD;
      addr_q   <= '0;
      data_q   <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_addr  <= '0;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
    end else begin
      state_q  <= state_d;
      kind_q   <= kind_d;
      if (state_q == S_IDLE && start) begin
        addr_q <= tgt_addr;
        data_q <= tgt_data;
      end
      done     <= done_d;
      fail     <= fail_d;
      fl_ce_n  <= !(wr_phase || rd_phase);
      fl_we_n  <= (state_q != S_WLOW);
      fl_oe_n  <= (state_q != S_RLOW);
      fl_addr  <= addr_q;
      fl_dq_o  <= dq_next;
      fl_dq_oe <= wr_phase;
    end
  end

  assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/flash_byte_prog_chk.sv
module flash_byte_prog_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_dq_o,
  input logic              fl_dq_oe
);
  AST_ADDR_STABLE_WE_LOW: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> $stable(fl_addr)); // R3
  AST_DATA_HELD_AT_WE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (fl_dq_oe && $stable(fl_dq_o))); // R3
  AST_BUS_FREE_FOR_READ: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe); // R5
  AST_RESULT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> (!busy && $past(busy))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(done && fail)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n)); // R9
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n); // R9
endmodule

bind flash_byte_prog flash_byte_prog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .fail(fail),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
  .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
);

// File: tb/flash_byte_prog_tb.sv
module flash_byte_prog_tb_top;
  localparam int SETUP = 2, WLOW = 3, WHIGH = 1, PROG = 20, TURN = 1, RD = 2, MAXT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] tgt_addr = '0;
  logic [7:0]  tgt_data = '0;
  logic        busy, done, fail;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [15:0] fl_addr;
  logic [7:0]  fl_dq_o, fl_dq_i;

  always #10 clk = ~clk;

  flash_byte_prog #(
    .P_SETUP(SETUP), .P_WE_LOW(WLOW), .P_WE_HIGH(WHIGH), .P_PROG(PROG),
    .P_TURN(TURN), .P_READ(RD), .P_MAX_TRIES(MAXT)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .busy(busy), .done(done), .fail(fail), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i)
  );

  int checks = 0, failures = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model state
  logic [15:0] m_addr;  logic [7:0] m_data;
  int bad_reads, progs, verifies, prog_rise_cyc, we_low_cnt, proto_bad;
  bit expect_data, verify_armed, prev_we, prev_oe;
  logic [15:0] fall_addr; logic [7:0] fall_dq;

  assign fl_dq_i = (verifies > bad_reads) ? m_data : ~m_data;

  task automatic model_reset(input logic [15:0] a, input logic [7:0] d, input int bad);
    m_addr = a; m_data = d; bad_reads = bad; progs = 0; verifies = 0;
    expect_data = 0; verify_armed = 0; proto_bad = 0; prog_rise_cyc = 0;
  endtask

  initial begin prev_we = 1; prev_oe = 1; we_low_cnt = 0; end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if ((!fl_we_n && !fl_oe_n) || (!fl_we_n && fl_ce_n)) proto_bad++;
      if (prev_we && !fl_we_n) begin
        fall_addr = fl_addr; fall_dq = fl_dq_o; we_low_cnt = 1;
        chk(fl_dq_oe, "R3 data driven at WE fall", fl_dq_oe, 1);
      end else if (!fl_we_n) we_low_cnt++;
      if (!prev_we && fl_we_n) begin
        chk(we_low_cnt == WLOW, "R3 WE low width", we_low_cnt, WLOW);
        chk(fl_addr == fall_addr, "R3 addr stable under WE", fl_addr, fall_addr);
        chk(fl_dq_oe && fl_dq_o == fall_dq, "R3 data held at WE rise", fl_dq_o, fall_dq);
        if (expect_data) begin
          chk(fl_addr == m_addr, "R2/R8 program address", fl_addr, m_addr);
          chk(fl_dq_o == m_data, "R2/R8 program data", fl_dq_o, m_data);
          progs++; expect_data = 0; prog_rise_cyc = cyc;
        end else if (fl_dq_o == 8'h40) expect_data = 1;
        else if (fl_dq_o == 8'hC0) begin
          chk(progs > 0 && cyc - prog_rise_cyc >= PROG + WLOW, "R4 program wait",
              cyc - prog_rise_cyc, PROG + WLOW);
          verifies++; verify_armed = 1;
        end else chk(0, "R2 unknown command", fl_dq_o, 8'h40);
      end
      if (prev_oe && !fl_oe_n) begin
        chk(verify_armed, "R5 read follows C0h", verify_armed, 1);
        chk(!fl_dq_oe, "R5 bus released during read", fl_dq_oe, 0);
      end
      if (!prev_oe && fl_oe_n) verify_armed = 0;
    end
    prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  typedef struct packed {
    logic [15:0] a; logic [7:0] d; logic [3:0] bad; logic exp_fail;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{16'h1234, 8'hA5, 4'd0, 1'b0},
    '{16'hFFFF, 8'h40, 4'd1, 1'b0},
    '{16'h0000, 8'hC0, 4'd4, 1'b0},
    '{16'h8001, 8'h00, 4'd5, 1'b1},
    '{16'h7FFE, 8'hFF, 4'd7, 1'b1},
    '{16'h0F0F, 8'h3C, 4'd2, 1'b0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int results, got_done, got_fail, n;
    model_reset(16'h0, 8'h0, 0);
    repeat (3) @(negedge clk);
    chk(fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 pins idle in reset",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && fl_ce_n && fl_we_n && fl_oe_n, "R1 idle after reset",
        {busy, done, fail}, 0);
    for (int i = 0; i < 6; i++) begin
      model_reset(VEC[i].a, VEC[i].d, int'(VEC[i].bad));
      tgt_addr = VEC[i].a; tgt_data = VEC[i].d; start = 1;
      @(negedge clk); start = 0;
      results = 0; got_done = 0; got_fail = 0; n = 0;
      while (!(done || fail) && n < 20000) begin
        @(negedge clk); n++;
        if (n == 30 || n == 200) begin   // R8: start while busy
          tgt_addr = ~VEC[i].a; tgt_data = ~VEC[i].d; start = 1;
          @(negedge clk); start = 0; n++;
        end
      end
      got_done = done; got_fail = fail;
      chk(!busy, "R6 busy low with result", busy, 0);
      chk(got_fail == VEC[i].exp_fail && got_done == !VEC[i].exp_fail,
          VEC[i].exp_fail ? "R7 fail reported" : "R6 done reported",
          {got_done, got_fail}, {!VEC[i].exp_fail, VEC[i].exp_fail});
      n = (int'(VEC[i].bad) + 1 < MAXT) ? int'(VEC[i].bad) + 1 : MAXT;
      chk(progs == n, "R7 program attempts", progs, n);
      @(negedge clk);
      chk(!done && !fail, "R6 result is one pulse", {done, fail}, 0);
      repeat (60) begin
        @(negedge clk);
        if (busy || done || fail) results++;
      end
      chk(results == 0, "R8 no extra run from ignored start", results, 0);
      chk(proto_bad == 0, "R9 strobe exclusion", proto_bad, 0);
    end
    rst = 1; @(negedge clk); @(negedge clk);
    chk(!busy && fl_ce_n && !fl_dq_oe, "R1 reset returns idle", busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule